// File: doc/BRIEF.md
# Ring-Buffer Command Stream Parser

This block drains a stream of 32-bit command words that a producer places in a circular region of word-addressed memory. The first four memory words form a header of byte offsets: the lower bound of the ring, the upper bound, the producer's write position and the consumer's read position. A pulse on `sync_req` starts one parsing pass. The pass reads the header, works out how many whole words are waiting, and then takes one command at a time: a code word followed by that command's arguments.

Three drawing operations go to downstream engines through a valid/ready handshake: a redraw rectangle, a solid fill and a rectangle copy. The arguments of commands the block recognises but does not carry out are read and dropped, so the stream stays aligned. A command whose arguments have not all arrived is left untouched for a later pass. When the pass ends, the block writes the final read position back into the header and drops `busy`. No pass takes place unless the device is both enabled and configured.

Top module: `cmdring_parser`

## Requirements
- R1: A `sync_req` pulse while `busy` is low raises `busy` in the next cycle. `busy` stays high until the pass has finished and then returns low.
- R2: If `dev_enable` or `dev_configured` is low when `sync_req` arrives, the pass issues no memory read, no memory write and no dispatch. The header read position is left unchanged.
- R3: The number of available words is (write position − read position) / 4. When that difference is negative, (upper bound − lower bound) is added first. Every complete command within that count is processed in a single pass.
- R4: Each word read advances the read position by 4 bytes. When the new value is equal to or above the upper bound, it becomes the lower bound.
- R5: Codes 1 and 25 take four arguments (x, y, width, height). They are dispatched with `cmd_op` = 1 and the arguments in slots 0..3 of `cmd_args` (slot k is bits 32k+31:32k).
- R6: Code 2 takes five arguments (colour, x, y, width, height) and is dispatched with `cmd_op` = 2 in slots 0..4. Code 3 takes six arguments (source x, source y, destination x, destination y, width, height) and is dispatched with `cmd_op` = 3 in slots 0..5.
- R7: If fewer words remain than a command's arguments need, the read position is restored to that command's code word, the pass ends, and that command is not dispatched.
- R8: Codes 13, 14 and 28 are consumed with 6, 7 and 12 argument words respectively and are not dispatched.
- R9: Codes 0, 26, 27, 29, 30 and every code not named in R5, R6 or R8 consume only their code word and are not dispatched.
- R10: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_op` and `cmd_args` hold their values into the next cycle.
- R11: Each enabled pass ends with exactly one memory write: the final read position, written to word address 3.
- R12: After reset, `busy`, `cmd_valid`, `mem_rd_en` and `mem_wr_en` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_enable | input | 1 | Device enabled |
| dev_configured | input | 1 | Ring header has been set up |
| sync_req | input | 1 | Start one parsing pass |
| busy | output | 1 | Pass in progress |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | ADDR_W | Word address of the read |
| mem_rd_data | input | 32 | Read data, valid one cycle after the strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | ADDR_W | Word address of the write |
| mem_wr_data | output | 32 | Write data (final read position) |
| cmd_valid | output | 1 | Drawing command offered |
| cmd_ready | input | 1 | Engine accepts the command |
| cmd_op | output | 2 | 1 redraw, 2 fill, 3 copy |
| cmd_args | output | NARG*32 | Argument slots, slot 0 in the low bits |

## Verification
The bench builds the block with ADDR_W = 10 and NARG = 6, and its ring runs from byte 16 up to byte 80. That leaves sixteen ring words, so a few commands are enough to cross the wrap point, to start a pass with the write position below the read position, and to split a command across the wrap. Six argument slots match the largest dispatched command, and the 12-argument skip reads well past the last slot. This shows that arguments beyond the slots are dropped without disturbing the stream.

// File: rtl/cmdring_pkg.sv
package cmdring_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        OP_NONE   = 2'd0,
        OP_REDRAW = 2'd1,
        OP_FILL   = 2'd2,
        OP_COPY   = 2'd3
    } op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HDR,
        ST_HDR_CAP,
        ST_LEN,
        ST_CODE,
        ST_DEC,
        ST_ARG,
        ST_ARG_CAP,
        ST_DISP,
        ST_WB,
        ST_DONE
    } state_e;

    typedef struct packed {
        logic [3:0] need;
        op_e        op;
    } dec_t;

    // step a byte offset by one word, folding back to the lower bound
    function automatic logic [WORD_W-1:0] ring_step(
        input logic [WORD_W-1:0] ptr,
        input logic [WORD_W-1:0] lo,
        input logic [WORD_W-1:0] hi
    );
        logic [WORD_W-1:0] nxt;
        nxt = ptr + WORD_W'(4);
        return (nxt >= hi) ? lo : nxt;
    endfunction

endpackage

// File: rtl/cmdring_avail.sv
module cmdring_avail
    import cmdring_pkg::*;
(
    input  logic [WORD_W-1:0] lo,
    input  logic [WORD_W-1:0] hi,
    input  logic [WORD_W-1:0] wr_pos,
    input  logic [WORD_W-1:0] rd_pos,
    output logic [WORD_W-1:0] words
);
    localparam int EXT_W = WORD_W + 2;

    logic signed [EXT_W-1:0] diff;
    logic signed [EXT_W-1:0] span;

    always_comb begin
        diff = $signed({2'b00, wr_pos}) - $signed({2'b00, rd_pos});
        span = $signed({2'b00, hi}) - $signed({2'b00, lo});
        if (diff < 0) diff = diff + span;
        // a header that is still inconsistent yields nothing to parse
        words = diff[EXT_W-1] ? '0 : WORD_W'(diff >>> 2);
    end
endmodule

// File: rtl/cmdring_decode.sv
module cmdring_decode
    import cmdring_pkg::*;
(
    input  logic [WORD_W-1:0] code,
    output dec_t              dec
);
    always_comb begin
        dec = '{need: 4'd0, op: OP_NONE};
        unique case (code)
            32'd1, 32'd25: dec = '{need: 4'd4,  op: OP_REDRAW};
            32'd2:         dec = '{need: 4'd5,  op: OP_FILL};
            32'd3:         dec = '{need: 4'd6,  op: OP_COPY};
            32'd13:        dec = '{need: 4'd6,  op: OP_NONE};
            32'd14:        dec = '{need: 4'd7,  op: OP_NONE};
            32'd28:        dec = '{need: 4'd12, op: OP_NONE};
            default:       dec = '{need: 4'd0,  op: OP_NONE};
        endcase
    end
endmodule

// File: rtl/cmdring_parser.sv
module cmdring_parser
    import cmdring_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int NARG   = 6
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   dev_enable,
    input  logic                   dev_configured,
    input  logic                   sync_req,
    output logic                   busy,
    output logic                   mem_rd_en,
    output logic [ADDR_W-1:0]      mem_rd_addr,
    input  logic [31:0]            mem_rd_data,
    output logic                   mem_wr_en,
    output logic [ADDR_W-1:0]      mem_wr_addr,
    output logic [31:0]            mem_wr_data,
    output logic                   cmd_valid,
    input  logic                   cmd_ready,
    output logic [1:0]             cmd_op,
    output logic [NARG*WORD_W-1:0] cmd_args
);
    localparam int HDR_WORDS = 4;
    localparam int HIDX_W    = $clog2(HDR_WORDS);
    localparam logic [ADDR_W-1:0] RD_POS_ADDR = ADDR_W'(HDR_WORDS - 1);

    state_e              state_q;
    logic [HIDX_W-1:0]   hidx_q;
    logic [WORD_W-1:0]   lo_q, hi_q, wr_pos_q, rd_pos_q, start_q, len_q;
    logic [3:0]          need_q, argi_q;
    op_e                 op_q;
    logic [WORD_W-1:0]   arg_q [NARG];
    logic [WORD_W-1:0]   avail_words;
    logic [WORD_W-1:0]   rd_next;
    dec_t                dec;

    cmdring_avail u_avail (
        .lo     (lo_q),
        .hi     (hi_q),
        .wr_pos (wr_pos_q),
        .rd_pos (rd_pos_q),
        .words  (avail_words)
    );

    cmdring_decode u_dec (
        .code (mem_rd_data),
        .dec  (dec)
    );

    assign rd_next = ring_step(rd_pos_q, lo_q, hi_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            hidx_q   <= '0;
            lo_q     <= '0;
            hi_q     <= '0;
            wr_pos_q <= '0;
            rd_pos_q <= '0;
            start_q  <= '0;
            len_q    <= '0;
            need_q   <= '0;
            argi_q   <= '0;
            op_q     <= OP_NONE;
            for (int i = 0; i < NARG; i++) arg_q[i] <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (sync_req) begin
                        hidx_q  <= '0;
                        state_q <= (dev_enable && dev_configured) ? ST_HDR : ST_DONE;
                    end
                end
                ST_HDR: state_q <= ST_HDR_CAP;
                ST_HDR_CAP: begin
                    unique case (hidx_q)
                        2'd0: lo_q     <= mem_rd_data;
                        2'd1: hi_q     <= mem_rd_data;
                        2'd2: wr_pos_q <= mem_rd_data;
                        default: rd_pos_q <= mem_rd_data;
                    endcase
                    hidx_q  <= hidx_q + 1'b1;
                    state_q <= (hidx_q == HIDX_W'(HDR_WORDS - 1)) ? ST_LEN : ST_HDR;
                end
                ST_LEN: begin
                    len_q   <= avail_words;
                    state_q <= ST_CODE;
                end
                ST_CODE: begin
                    if (len_q == '0) begin
                        state_q <= ST_WB;
                    end else begin
                        start_q  <= rd_pos_q;
                        rd_pos_q <= rd_next;
                        len_q    <= len_q - 1'b1;
                        state_q  <= ST_DEC;
                    end
                end
                ST_DEC: begin
                    if (WORD_W'(dec.need) > len_q) begin
                        rd_pos_q <= start_q;      // leave the partial command in place
                        state_q  <= ST_WB;
                    end else if (dec.need == 4'd0) begin
                        state_q <= ST_CODE;
                    end else begin
                        need_q  <= dec.need;
                        op_q    <= dec.op;
                        argi_q  <= '0;
                        state_q <= ST_ARG;
                    end
                end
                ST_ARG: begin
                    rd_pos_q <= rd_next;
                    len_q    <= len_q - 1'b1;
                    state_q  <= ST_ARG_CAP;
                end
                ST_ARG_CAP: begin
                    for (int i = 0; i < NARG; i++) begin
                        if (argi_q == 4'(i)) arg_q[i] <= mem_rd_data;
                    end
                    argi_q <= argi_q + 1'b1;
                    if (argi_q + 4'd1 == need_q)
                        state_q <= (op_q != OP_NONE) ? ST_DISP : ST_CODE;
                    else
                        state_q <= ST_ARG;
                end
                ST_DISP: if (cmd_ready) state_q <= ST_CODE;
                ST_WB:   state_q <= ST_DONE;
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy        = (state_q != ST_IDLE);
    assign mem_rd_en   = (state_q == ST_HDR) || (state_q == ST_ARG) ||
                         ((state_q == ST_CODE) && (len_q != '0));
    assign mem_rd_addr = (state_q == ST_HDR) ? ADDR_W'(hidx_q)
                                             : rd_pos_q[ADDR_W+1:2];
    assign mem_wr_en   = (state_q == ST_WB);
    assign mem_wr_addr = RD_POS_ADDR;
    assign mem_wr_data = rd_pos_q;
    assign cmd_valid   = (state_q == ST_DISP);
    assign cmd_op      = (state_q == ST_DISP) ? op_q : OP_NONE;

    for (genvar g = 0; g < NARG; g++) begin : g_args
        assign cmd_args[g*WORD_W +: WORD_W] = arg_q[g];
    end
endmodule

// File: rtl/cmdring_checker.sv
module cmdring_checker #(
    parameter int NARG = 6
) (
    input logic                clk,
    input logic                rst,
    input logic                dev_enable,
    input logic                dev_configured,
    input logic                sync_req,
    input logic                busy,
    input logic                mem_rd_en,
    input logic                mem_wr_en,
    input logic                cmd_valid,
    input logic                cmd_ready,
    input logic [1:0]          cmd_op,
    input logic [NARG*32-1:0]  cmd_args
);
    a_r1_busy_rises: assert property (@(posedge clk) disable iff (rst)
        (!busy && sync_req) |=> busy);

    a_r2_gated_pass: assert property (@(posedge clk) disable iff (rst)
        (!busy && sync_req && !(dev_enable && dev_configured))
            |=> (!mem_rd_en && !mem_wr_en && !cmd_valid) ##1 !busy);

    a_r5_dispatch_op: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (cmd_op != 2'd0) && busy && !mem_rd_en);

    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=> cmd_valid && $stable(cmd_op) && $stable(cmd_args));

    a_r11_single_write: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |=> !mem_wr_en && !mem_rd_en && busy ##1 !busy);

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_rd_en && !mem_wr_en && !cmd_valid);
endmodule

bind cmdring_parser cmdring_checker #(.NARG(NARG)) u_chk (.*);

// File: tb/tb_cmdring_parser.sv
`timescale 1ns/1ps
module tb_cmdring_parser;
    localparam int AW = 10;
    localparam int NA = 6;
    localparam int RING_LO = 16;
    localparam int RING_HI = 80;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst = 1'b1;
    logic dev_enable = 1'b0, dev_configured = 1'b0, sync_req = 1'b0;
    logic busy, mem_rd_en, mem_wr_en, cmd_valid;
    logic cmd_ready = 1'b0;
    logic [AW-1:0] mem_rd_addr, mem_wr_addr;
    logic [31:0] mem_rd_data, mem_wr_data;
    logic [1:0] cmd_op;
    logic [NA*32-1:0] cmd_args;

    cmdring_parser #(.ADDR_W(AW), .NARG(NA)) dut (.*);

    logic [31:0] mem [0:(1<<AW)-1];
    always @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];
        if (mem_wr_en) mem[mem_wr_addr] <= mem_wr_data;
    end

    int n_chk = 0, n_fail = 0;
    int rd_seen = 0, wr_seen = 0, cyc = 0, wp = 0;
    int exp_op[$];
    logic [NA*32-1:0] exp_args[$];
    int exp_stop;
    logic [7:0] lfsr = 8'hA5;
    bit prev_wait = 0;
    logic [1:0] prev_op;
    logic [NA*32-1:0] prev_args;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int adv(input int p);
        int n;
        n = p + 4;
        return (n >= int'(mem[1])) ? int'(mem[0]) : n;
    endfunction

    // reference: parse the ring behaviourally from the requirements
    task automatic model(input bit en, input bit cfg);
        int st, start, len, code, need, op;
        logic [NA*32-1:0] a;
        exp_stop = int'(mem[3]);
        if (!(en && cfg)) return;
        st  = int'(mem[3]);
        len = int'(mem[2]) - st;
        if (len < 0) len += int'(mem[1]) - int'(mem[0]);
        len = len / 4;
        while (len > 0) begin
            start = st; code = int'(mem[st/4]); st = adv(st); len--;
            op = 0; need = 0;
            case (code)
                1, 25: begin need = 4; op = 1; end
                2:     begin need = 5; op = 2; end
                3:     begin need = 6; op = 3; end
                13:    need = 6;
                14:    need = 7;
                28:    need = 12;
                default: need = 0;
            endcase
            if (need > len) begin st = start; break; end
            a = '0;
            for (int i = 0; i < need; i++) begin
                if (i < NA) a[i*32 +: 32] = mem[st/4];
                st = adv(st); len--;
            end
            if (op != 0) begin exp_op.push_back(op); exp_args.push_back(a); end
        end
        exp_stop = st;
    endtask

    // per-clock comparison against the model's dispatch queue
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_rd_en) rd_seen++;
            if (mem_wr_en) begin
                wr_seen++;
                check(mem_wr_addr == AW'(3), "R11 write address", 32'(mem_wr_addr), 32'd3);
            end
            if (prev_wait)
                check(cmd_valid && cmd_op == prev_op && cmd_args == prev_args,
                      "R10 held offer", {30'd0, cmd_op}, {30'd0, prev_op});
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            cmd_ready = lfsr[0] | lfsr[3];
            prev_wait = cmd_valid && !cmd_ready;
            prev_op = cmd_op;
            prev_args = cmd_args;
            if (cmd_valid && cmd_ready) begin
                if (exp_op.size() == 0) begin
                    check(1'b0, "R9 unexpected dispatch", {30'd0, cmd_op}, 32'd0);
                end else begin
                    int eo, n;
                    logic [NA*32-1:0] ea;
                    eo = exp_op.pop_front();
                    ea = exp_args.pop_front();
                    n = (eo == 1) ? 4 : (eo == 2) ? 5 : 6;
                    check(int'(cmd_op) == eo, (eo == 1) ? "R5 op" : "R6 op", {30'd0, cmd_op}, 32'(eo));
                    for (int i = 0; i < n; i++)
                        check(cmd_args[i*32 +: 32] == ea[i*32 +: 32],
                              (eo == 1) ? "R5 argument" : "R6 argument",
                              cmd_args[i*32 +: 32], ea[i*32 +: 32]);
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL R1 watchdog expired actual=busy expected=idle");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic ring_start(input int st);
        mem[0] = RING_LO; mem[1] = RING_HI; mem[3] = st; mem[2] = st; wp = st;
    endtask
    task automatic put(input int w);
        mem[wp/4] = w; wp += 4;
        if (wp >= RING_HI) wp = RING_LO;
    endtask
    task automatic publish();
        mem[2] = wp;
    endtask

    task automatic run(input bit en, input bit cfg, input string tag);
        model(en, cfg);
        rd_seen = 0; wr_seen = 0;
        @(negedge clk);
        dev_enable = en; dev_configured = cfg; sync_req = 1'b1;
        @(negedge clk);
        sync_req = 1'b0;
        check(busy == 1'b1, "R1 busy after sync", {31'd0, busy}, 32'd1);
        while (busy) @(negedge clk);
        check(exp_op.size() == 0, "R3 all complete commands dispatched", exp_op.size(), 0);
        check(mem[3] == exp_stop, tag, mem[3], exp_stop);
        if (en && cfg) check(wr_seen == 1, "R11 one write per pass", wr_seen, 1);
        else check(rd_seen == 0 && wr_seen == 0, "R2 no memory access", rd_seen + wr_seen, 0);
        exp_op.delete(); exp_args.delete();
    endtask

    initial begin
        for (int i = 0; i < (1<<AW); i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        check(!busy && !cmd_valid && !mem_rd_en && !mem_wr_en, "R12 reset state",
              {28'd0, busy, cmd_valid, mem_rd_en, mem_wr_en}, 32'd0);
        rst = 1'b0;

        ring_start(16);                                   // redraw and fill, no wrap
        put(1); put(11); put(12); put(13); put(14);
        put(2); put(32'hFF00AA); put(5); put(6); put(7); put(8);
        publish(); run(1, 1, "R4 read position after R5/R6");

        put(3); put(1); put(2); put(3); put(4); put(5); put(6);   // copy split across wrap
        put(25); put(21); put(22); put(23); put(24);
        publish(); run(1, 1, "R4 wrapped read position");

        put(13); for (int i = 0; i < 6; i++) put(100 + i);         // skips
        put(14); for (int i = 0; i < 7; i++) put(200 + i);
        publish(); run(1, 1, "R8 skip 13/14");
        put(28); for (int i = 0; i < 12; i++) put(300 + i);
        publish(); run(1, 1, "R8 skip 28");

        put(0); put(26); put(27); put(29); put(30); put(7); put(99);  // single-word codes
        put(1); put(41); put(42); put(43); put(44);
        publish(); run(1, 1, "R9 single-word codes keep alignment");

        put(3); put(51); put(52); put(53);                // partial copy
        publish(); run(1, 1, "R7 rewind to code word");
        put(54); put(55); put(56);
        publish(); run(1, 1, "R7 completed after rewind");

        run(1, 1, "R3 empty ring");

        put(1); put(61); put(62); put(63); put(64);
        publish();
        run(0, 1, "R2 disabled keeps position");
        run(1, 0, "R2 unconfigured keeps position");
        run(1, 1, "R2 pending command after enabling");

        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule